// File: doc/BRIEF.md
# Clock Gate and Reset Controller

This block sits on a 16-bit register bus and drives the clock gates and reset holds of a set of peripheral blocks. Software turns clocks on by writing a mask to one address and turns them off by writing a mask to a second address. A one bit selects a clock and a zero bit leaves it untouched, so no read-modify-write is needed. Some clocks belong to hardware. Writes to those bits have no effect, and their gates stay on.

Reset holds live in one plain read/write word. A control word carries a performance level and two audio-port oscillator selects. The crystal oscillator request is on whenever either select is set. Changing the performance level drops a lock status bit for a configurable number of cycles, which software polls. A separate word holds per-port audio clock enables, and another holds a power-management enable.

Top module: `clkrst_ctrl`

## Requirements
- R1: A write to address 0 enables every software-owned clock whose wdata bit is one; clocks whose bit is zero keep their state.
- R2: A write to address 1 disables every software-owned clock whose wdata bit is one; clocks whose bit is zero keep their state.
- R3: Clocks in HW_MASK are unaffected by writes to addresses 0 and 1 and their clk_en bits stay at one.
- R4: Reading address 0 or address 1 returns the current clk_en vector.
- R5: Address 2 is a read/write reset word: a one bit holds the matching block in reset on rst_hold, and a zero bit releases it. Bits outside RST_IMPL always read 0 and never assert.
- R6: After reset, clk_en equals HW_MASK, rst_hold equals RST_IMPL, perf_level is 0, the lock bit is 1, and osc_on, aud_clk_en and pm_en are 0.
- R7: Bits [2:0] of the control word at address 3 set perf_level, with 0 = best, 1 = high, 2 = intermediate, 3 = low and 4 = low power. The field reads back from the same bits.
- R8: Bit 0 of address 5 is PLL lock. It reads 0 from the cycle after a write that changes perf_level, for LOCK_CYCLES cycles, and then reads 1. A write that leaves the level unchanged does not drop it.
- R9: osc_on is 1 while either control-word select bit 4 or bit 5 is set. It drops only once both are clear.
- R10: Bits [1:0] of address 4 drive aud_clk_en[1:0] and read back.
- R11: Bit 0 of address 6 drives pm_en and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| clk_en | output | NUM_CLK | Per-peripheral clock gate enables |
| rst_hold | output | NUM_RST | Per-peripheral reset holds (1 = in reset) |
| perf_level | output | 3 | Performance level |
| osc_on | output | 1 | Crystal oscillator request |
| aud_clk_en | output | 2 | Audio port clock enables |
| pm_en | output | 1 | Power-management enable |

## Verification
The bench writes all-ones masks to both gate addresses. A design that let software touch hardware-owned clocks would drop bits 8 and 9 of clk_en.

It clears the select bits one at a time. A design that tied the oscillator to a single select would turn osc_on off while the other port still uses it.

It counts the exact cycle on which lock returns after a level change. It also rewrites the same level, so an off-by-one timer or a timer that restarts on every write shows up.

A write of all ones to the reset word checks that the bit with no reset stays at zero.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [2:0] {
        PERF_BEST   = 3'd0,
        PERF_HIGH   = 3'd1,
        PERF_MID    = 3'd2,
        PERF_LOW    = 3'd3,
        PERF_LOWPWR = 3'd4
    } perf_e;

    localparam logic [ADDR_W-1:0] A_GATE_ON  = 3'd0;
    localparam logic [ADDR_W-1:0] A_GATE_OFF = 3'd1;
    localparam logic [ADDR_W-1:0] A_RST      = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL     = 3'd3;
    localparam logic [ADDR_W-1:0] A_AUD      = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT     = 3'd5;
    localparam logic [ADDR_W-1:0] A_PM       = 3'd6;

    localparam int unsigned SEL0_BIT = 4;
    localparam int unsigned SEL1_BIT = 5;
endpackage

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
    parameter int unsigned      NUM     = 16,
    parameter logic [NUM-1:0]   HW_MASK = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_we,
    input  logic           clr_we,
    input  logic [NUM-1:0] mask,
    output logic [NUM-1:0] gate
);
    localparam logic [NUM-1:0] SW_MASK = ~HW_MASK;

    logic [NUM-1:0] gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (set_we) gate_d = gate_d | (mask & SW_MASK);
        if (clr_we) gate_d = gate_d & ~(mask & SW_MASK);
        gate_d = gate_d | HW_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= HW_MASK;
        else        gate_q <= gate_d;
    end

    assign gate = gate_q;

    // R1
    p_set_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((gate_q & $past(mask) & SW_MASK) == ($past(mask) & SW_MASK)));
    // R2
    p_clr_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((gate_q & $past(mask) & SW_MASK) == '0));
    // R3
    p_hw_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q & HW_MASK) == HW_MASK);
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int unsigned LOCK_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic locked
);
    localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)           cnt_d = CNT_W'(LOCK_CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign locked = (cnt_q == '0);

    // R8
    p_lock_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !locked);
endmodule

// File: rtl/clkrst_ctrl.sv
module clkrst_ctrl
    import clkrst_pkg::*;
#(
    parameter int unsigned        NUM_CLK     = 16,
    parameter int unsigned        NUM_RST     = 16,
    parameter logic [NUM_CLK-1:0] HW_MASK     = 16'h0300,
    parameter logic [NUM_RST-1:0] RST_IMPL    = 16'hFFF7,
    parameter int unsigned        LOCK_CYCLES = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_CLK-1:0] clk_en,
    output logic [NUM_RST-1:0] rst_hold,
    output logic [2:0]         perf_level,
    output logic               osc_on,
    output logic [1:0]         aud_clk_en,
    output logic               pm_en
);
    typedef struct packed {
        logic [NUM_RST-1:0] rst;
        perf_e              perf;
        logic [1:0]         sel;
        logic [1:0]         aud;
        logic               pm;
        logic               osc;
    } regs_t;

    localparam regs_t RESET_VAL = '{rst: RST_IMPL, perf: PERF_BEST,
                                    sel: 2'b00, aud: 2'b00, pm: 1'b0, osc: 1'b0};

    regs_t r_d, r_q;
    logic  gate_set_we, gate_clr_we, restart_lock, locked;

    assign gate_set_we  = wr_en && (addr == A_GATE_ON);
    assign gate_clr_we  = wr_en && (addr == A_GATE_OFF);
    assign restart_lock = wr_en && (addr == A_CTRL) && (wdata[2:0] != r_q.perf);

    clk_gate_bank #(.NUM(NUM_CLK), .HW_MASK(HW_MASK)) u_gates (
        .clk(clk), .rst_n(rst_n), .set_we(gate_set_we), .clr_we(gate_clr_we),
        .mask(wdata[NUM_CLK-1:0]), .gate(clk_en)
    );

    pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .restart(restart_lock), .locked(locked)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                A_RST:  r_d.rst = wdata[NUM_RST-1:0] & RST_IMPL;
                A_CTRL: begin
                    r_d.perf = perf_e'(wdata[2:0]);
                    r_d.sel  = {wdata[SEL1_BIT], wdata[SEL0_BIT]};
                end
                A_AUD:  r_d.aud = wdata[1:0];
                A_PM:   r_d.pm  = wdata[0];
                default: ;
            endcase
        end
        r_d.osc = |r_d.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_GATE_ON, A_GATE_OFF: rdata[NUM_CLK-1:0] = clk_en;
            A_RST:  rdata[NUM_RST-1:0] = r_q.rst;
            A_CTRL: begin
                rdata[2:0]      = r_q.perf;
                rdata[SEL0_BIT] = r_q.sel[0];
                rdata[SEL1_BIT] = r_q.sel[1];
            end
            A_AUD:  rdata[1:0] = r_q.aud;
            A_STAT: rdata[0]   = locked;
            A_PM:   rdata[0]   = r_q.pm;
            default: ;
        endcase
    end

    assign rst_hold   = r_q.rst;
    assign perf_level = r_q.perf;
    assign osc_on     = r_q.osc;
    assign aud_clk_en = r_q.aud;
    assign pm_en      = r_q.pm;

    // R5
    p_rst_impl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_hold & ~RST_IMPL) == '0);
    // R9
    p_osc_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_on) |-> (r_q.sel == 2'b00));
    // R9
    p_osc_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_on) |-> (r_q.sel != 2'b00));
endmodule

// File: tb/clkrst_ctrl_bench.sv
module clkrst_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] clk_en, rst_hold;
    logic [2:0]  perf_level;
    logic        osc_on, pm_en;
    logic [1:0]  aud_clk_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkrst_ctrl u_clkrst_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .clk_en(clk_en), .rst_hold(rst_hold),
        .perf_level(perf_level), .osc_on(osc_on), .aud_clk_en(aud_clk_en),
        .pm_en(pm_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R6 clk_en", clk_en, 16'h0300);
        chk("R6 rst_hold", rst_hold, 16'hFFF7);
        chk("R6 perf", perf_level, 0);
        chk("R6 osc", osc_on, 0);
        chk("R6 aud", aud_clk_en, 0);
        chk("R6 pm", pm_en, 0);
        rd(3'd5, v); chk("R6 lock", v[0], 1);
        rd(3'd0, v); chk("R4 read gates", v, 16'h0300);
    endtask

    task automatic t_set();
        logic [15:0] v;
        wr(3'd0, 16'h0011); chk("R1 set", clk_en, 16'h0311);
        wr(3'd0, 16'h0004); chk("R1 zero bits kept", clk_en, 16'h0315);
        rd(3'd1, v); chk("R4 read off addr", v, 16'h0315);
    endtask

    task automatic t_clr();
        logic [15:0] v;
        wr(3'd1, 16'h0001); chk("R2 clear", clk_en, 16'h0314);
        rd(3'd0, v); chk("R4 read on addr", v, 16'h0314);
    endtask

    task automatic t_hw();
        wr(3'd1, 16'hFFFF); chk("R3 clear all", clk_en, 16'h0300);
        wr(3'd0, 16'hFCFF); chk("R3 set others", clk_en, 16'hFFFF);
        wr(3'd1, 16'h0300); chk("R3 clear hw only", clk_en, 16'hFFFF);
        wr(3'd1, 16'hFFFF); chk("R3 clear again", clk_en, 16'h0300);
    endtask

    task automatic t_rst();
        logic [15:0] v;
        wr(3'd2, 16'h0000); chk("R5 release", rst_hold, 16'h0000);
        wr(3'd2, 16'hFFFF); chk("R5 hold impl", rst_hold, 16'hFFF7);
        rd(3'd2, v); chk("R5 readback", v, 16'hFFF7);
        wr(3'd2, 16'h00F0); chk("R5 pattern", rst_hold, 16'h00F0);
    endtask

    task automatic t_perf();
        logic [15:0] v;
        wr(3'd3, 16'h0004); chk("R7 low power", perf_level, 4);
        rd(3'd3, v); chk("R7 readback", v[2:0], 4);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        wr(3'd3, 16'h0002);
        rd(3'd5, v); chk("R8 drop", v[0], 0);
        repeat (5) @(negedge clk);
        rd(3'd5, v); chk("R8 still low", v[0], 0);
        @(negedge clk);
        rd(3'd5, v); chk("R8 relock", v[0], 1);
        wr(3'd3, 16'h0002);
        rd(3'd5, v); chk("R8 same level no drop", v[0], 1);
    endtask

    task automatic t_osc();
        wr(3'd3, 16'h0010); chk("R9 sel0 on", osc_on, 1);
        wr(3'd3, 16'h0030); chk("R9 both", osc_on, 1);
        wr(3'd3, 16'h0020); chk("R9 sel1 keeps", osc_on, 1);
        wr(3'd3, 16'h0000); chk("R9 both clear", osc_on, 0);
        wr(3'd3, 16'h0020); chk("R9 sel1 on", osc_on, 1);
        wr(3'd3, 16'h0000); chk("R9 off", osc_on, 0);
    endtask

    task automatic t_aud();
        logic [15:0] v;
        wr(3'd4, 16'h0002); chk("R10 port1", aud_clk_en, 2);
        wr(3'd4, 16'h0001); chk("R10 port0", aud_clk_en, 1);
        rd(3'd4, v); chk("R10 readback", v[1:0], 1);
    endtask

    task automatic t_pm();
        logic [15:0] v;
        wr(3'd6, 16'h0001); chk("R11 pm on", pm_en, 1);
        rd(3'd6, v); chk("R11 readback", v[0], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_clr();
        t_hw();
        t_rst();
        t_perf();
        t_lock();
        t_osc();
        t_aud();
        t_pm();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule